// File: doc/BRIEF.md
# Cache maintenance sequencer

This block carries out maintenance commands on a small instruction cache and a small write-back data cache. Both caches sit inside the block as register arrays. A command names one of two operations: invalidate-only, or push-then-invalidate. It also carries a two-bit mask that picks which caches it acts on, and one of three scopes: a single line, every line of one 4 KB page, or the whole cache. The line and page scopes also take an address.

The sequencer steps through the tag arrays one index per cycle. When a valid data line is dirty and the command pushes, the sequencer writes that line to memory as a four-word burst. It clears the line's valid and dirty bits only after the burst has finished. Lines that do not match, or are not valid, produce no memory traffic. The `busy` output stays high while a command is being worked on. Commands offered during that time are not taken.

A fill port loads lines into the caches, and a probe port reports whether an address hits, so the surrounding logic can use the caches. Each cache has 64 direct-mapped lines of 16 bytes. A line's address is {tag, index, offset}, with the index in address bits [9:4] and the tag in bits [31:10].

Top module: `cmo_seq`

## Requirements
- R1: After reset, every line of both caches is invalid and not dirty. `busy` and `wr_valid` are low, and `cmd_ready` is high.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` equals `!busy`. `busy` is high from the cycle after acceptance until the last line has been processed. A command offered while `busy` is high is ignored.
- R3: A fill writes the valid bit and tag of the line at the index given by the fill address. `fill_dcache` = 1 selects the data cache (which also stores the dirty flag and 128-bit data), and 0 selects the instruction cache (never dirty). A fill offered while `busy` is high is ignored. The probe reports hit (valid with equal tag) per cache, and the dirty flag of a data-cache hit.
- R4: Scope 0 (line) acts only on the line at index `cmd_addr[9:4]`, and only when its tag equals `cmd_addr[31:10]`. It takes exactly one cycle of `busy` when nothing is pushed.
- R5: Scope 1 (page) acts on every line whose line address bits [31:12], {tag, index}[27:8], equal `cmd_addr[31:12]`.
- R6: Scopes 2 and 3 act on every line of the selected caches. A page or whole-cache command without pushes keeps `busy` high for exactly 64 cycles.
- R7: `cmd_sel[0]` selects the instruction cache and `cmd_sel[1]` selects the data cache. Lines of an unselected cache are left unchanged.
- R8: Operation 0 (invalidate-only) clears the valid and dirty bits of matching lines and produces no write traffic.
- R9: Operation 1 (push) writes each matching, valid, dirty data line as four beats, in index order. Beat k has address {tag, index, k, 2'b00} and data bits [32k+31:32k] of the line, and `wr_last` marks beat 3. The line's valid bit is cleared only after that last beat is accepted.
- R10: A push never produces traffic for instruction-cache lines, clean lines or invalid lines. These are just invalidated when they match, or left alone when they do not.
- R11: The write port is valid/ready. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_last` hold steady. A beat moves on any edge where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 1 | 0 invalidate-only, 1 push-then-invalidate |
| cmd_sel | input | 2 | Bit 0 instruction cache, bit 1 data cache |
| cmd_scope | input | 2 | 0 line, 1 page, 2/3 whole cache |
| cmd_addr | input | 32 | Address for line and page scopes |
| busy | output | 1 | Command in progress |
| fill_en | input | 1 | Load one line |
| fill_dcache | input | 1 | 1 data cache, 0 instruction cache |
| fill_addr | input | 32 | Address of the line to load |
| fill_dirty | input | 1 | Dirty flag for a data-cache fill |
| fill_data | input | 128 | Line contents for a data-cache fill |
| probe_addr | input | 32 | Address to look up |
| probe_ihit | output | 1 | Instruction cache holds the address |
| probe_dhit | output | 1 | Data cache holds the address |
| probe_ddirty | output | 1 | Data cache line is held and dirty |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | 32 | Byte address of the beat |
| wr_data | output | 32 | Beat data |
| wr_last | output | 1 | Final beat of a line |

## Verification
The assertions check the write port's hold rules under back-pressure on every cycle. They also check that beats within a burst step by one word, that bursts start on a line boundary, that write traffic occurs only while busy, and that busy follows acceptance. Which lines a scope reaches, how the select mask and operation combine, and the resulting cache contents can only be shown by the bench's scenarios. The bench sweeps every operation, select and scope over a cache preloaded with a mix of matching, non-matching, clean, dirty and empty lines. It checks the exact sequence of write beats and probes every line afterwards.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  localparam logic OP_INV  = 1'b0;
  localparam logic OP_PUSH = 1'b1;

  localparam logic [1:0] SCOPE_LINE = 2'd0;
  localparam logic [1:0] SCOPE_PAGE = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_PUSH = 2'd2
  } walk_st_e;

  typedef struct packed {
    logic       op;
    logic [1:0] sel;
    logic [1:0] scope;
  } cmd_t;
endpackage

// File: rtl/cmo_scope_match.sv
module cmo_scope_match #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 6,
  parameter int OFF_W     = 4,
  parameter int PAGE_BITS = 12
) (
  input  logic [1:0]                    scope,
  input  logic [ADDR_W-1:0]             ref_addr,
  input  logic                          line_valid,
  input  logic [ADDR_W-IDX_W-OFF_W-1:0] line_tag,
  input  logic [IDX_W-1:0]              line_idx,
  output logic                          hit
);
  import cmo_pkg::*;

  localparam int LN_W  = ADDR_W - OFF_W;
  localparam int PG_LO = PAGE_BITS - OFF_W;

  logic [LN_W-1:0] line_no;
  logic            in_scope;

  always_comb begin
    line_no = {line_tag, line_idx};
    case (scope)
      SCOPE_LINE: in_scope = (line_no == ref_addr[ADDR_W-1:OFF_W]);
      SCOPE_PAGE: in_scope = (line_no[LN_W-1:PG_LO] == ref_addr[ADDR_W-1:PAGE_BITS]);
      default:    in_scope = 1'b1;
    endcase
    hit = line_valid & in_scope;
  end
endmodule

// File: rtl/cmo_tag_array.sv
module cmo_tag_array #(
  parameter int LINES     = 64,
  parameter int IDX_W     = 6,
  parameter int TAG_W     = 22,
  parameter bit HAS_DIRTY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_dirty,
  input  logic [IDX_W-1:0] pr_idx,
  output logic             pr_valid,
  output logic [TAG_W-1:0] pr_tag,
  output logic             pr_dirty
);
  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (fill_en) vld_q[fill_idx] <= 1'b1;
      if (clr_en)  vld_q[clr_idx]  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign pr_valid = vld_q[pr_idx];
  assign pr_tag   = tag_q[pr_idx];

  generate
    if (HAS_DIRTY) begin : g_dirty
      logic [LINES-1:0] drt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          drt_q <= '0;
        end else begin
          if (fill_en) drt_q[fill_idx] <= fill_dirty;
          if (clr_en)  drt_q[clr_idx]  <= 1'b0;
        end
      end
      assign rd_dirty = drt_q[rd_idx];
      assign pr_dirty = drt_q[pr_idx];
    end else begin : g_clean
      logic unused_fill_dirty;
      assign unused_fill_dirty = fill_dirty;
      assign rd_dirty = 1'b0;
      assign pr_dirty = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cmo_line_data.sv
module cmo_line_data #(
  parameter int LINES  = 64,
  parameter int IDX_W  = 6,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] mem_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_line;
  end

  assign rd_line = mem_q[rd_idx];
endmodule

// File: rtl/cmo_walker.sv
module cmo_walker #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int BEATS  = 4,
  parameter int LINES  = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  cmo_pkg::cmd_t                 cmd,
  input  logic [ADDR_W-1:0]             cmd_addr,
  output logic                          busy,
  output logic [1:0]                    cur_scope,
  output logic [ADDR_W-1:0]             cur_addr,
  output logic [$clog2(LINES)-1:0]      walk_idx,
  input  logic                          i_match,
  input  logic                          d_match,
  input  logic                          d_dirty,
  input  logic [ADDR_W-$clog2(LINES)-$clog2(BEATS)-$clog2(WORD_W/8)-1:0] d_tag,
  input  logic [WORD_W*BEATS-1:0]       line_data,
  output logic                          clr_i,
  output logic                          clr_d,
  output logic                          wr_valid,
  input  logic                          wr_ready,
  output logic [ADDR_W-1:0]             wr_addr,
  output logic [WORD_W-1:0]             wr_data,
  output logic                          wr_last
);
  import cmo_pkg::*;

  localparam int IDX_W  = $clog2(LINES);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(LINES - 1);
  localparam int OFF_W  = BEAT_W + BYTE_W;

  walk_st_e          st_q;
  cmd_t              cur_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BEAT_W-1:0] beat_q;

  logic i_sel, d_sel, need_push, last_line, beat_done, line_done;

  always_comb begin
    i_sel     = cur_q.sel[0] & i_match;
    d_sel     = cur_q.sel[1] & d_match;
    need_push = d_sel & d_dirty & (cur_q.op == OP_PUSH);
    last_line = (cur_q.scope == SCOPE_LINE) || (idx_q == LAST_IDX);
    beat_done = (st_q == ST_PUSH) && wr_ready && (beat_q == LAST_BEAT);
    line_done = ((st_q == ST_SCAN) && !need_push) || beat_done;
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign cur_scope = cur_q.scope;
  assign cur_addr  = addr_q;
  assign walk_idx  = idx_q;
  assign clr_i     = line_done & i_sel;
  assign clr_d     = line_done & d_sel;

  assign wr_valid = (st_q == ST_PUSH);
  assign wr_addr  = {d_tag, idx_q, beat_q, BYTE_W'(0)};
  assign wr_data  = line_data[int'(beat_q)*WORD_W +: WORD_W];
  assign wr_last  = (beat_q == LAST_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      addr_q <= '0;
      idx_q  <= '0;
      beat_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            cur_q  <= cmd;
            addr_q <= cmd_addr;
            idx_q  <= (cmd.scope == SCOPE_LINE) ? cmd_addr[OFF_W +: IDX_W] : '0;
            st_q   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (need_push) begin
            beat_q <= '0;
            st_q   <= ST_PUSH;
          end else if (last_line) begin
            st_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_PUSH: begin
          if (wr_ready) begin
            if (beat_q == LAST_BEAT) begin
              if (last_line) begin
                st_q <= ST_IDLE;
              end else begin
                idx_q <= idx_q + 1'b1;
                st_q  <= ST_SCAN;
              end
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmo_seq.sv
module cmo_seq #(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int BEATS     = 4,
  parameter int LINES     = 64,
  parameter int PAGE_BITS = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic                    cmd_op,
  input  logic [1:0]              cmd_sel,
  input  logic [1:0]              cmd_scope,
  input  logic [ADDR_W-1:0]       cmd_addr,
  output logic                    busy,
  input  logic                    fill_en,
  input  logic                    fill_dcache,
  input  logic [ADDR_W-1:0]       fill_addr,
  input  logic                    fill_dirty,
  input  logic [WORD_W*BEATS-1:0] fill_data,
  input  logic [ADDR_W-1:0]       probe_addr,
  output logic                    probe_ihit,
  output logic                    probe_dhit,
  output logic                    probe_ddirty,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [WORD_W-1:0]       wr_data,
  output logic                    wr_last
);
  import cmo_pkg::*;

  localparam int IDX_W  = $clog2(LINES);
  localparam int OFF_W  = $clog2(BEATS) + $clog2(WORD_W / 8);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = WORD_W * BEATS;

  logic [IDX_W-1:0]  fill_idx, probe_idx, walk_idx;
  logic [TAG_W-1:0]  fill_tag, probe_tag;
  logic              fill_ok;
  logic [1:0]        cur_scope;
  logic [ADDR_W-1:0] cur_addr;
  logic              clr_i, clr_d;
  logic              i_match, d_match;
  logic [LINE_W-1:0] line_data;
  cmd_t              cmd;

  logic              i_rd_valid, d_rd_valid, i_rd_dirty, d_rd_dirty;
  logic [TAG_W-1:0]  i_rd_tag, d_rd_tag, i_pr_tag, d_pr_tag;
  logic              i_pr_valid, d_pr_valid, i_pr_dirty, d_pr_dirty;

  assign fill_idx  = fill_addr[OFF_W +: IDX_W];
  assign fill_tag  = fill_addr[ADDR_W-1 -: TAG_W];
  assign probe_idx = probe_addr[OFF_W +: IDX_W];
  assign probe_tag = probe_addr[ADDR_W-1 -: TAG_W];
  assign fill_ok   = fill_en & ~busy;
  assign cmd       = '{op: cmd_op, sel: cmd_sel, scope: cmd_scope};

  cmo_tag_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .HAS_DIRTY(1'b0)) u_itags (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_ok & ~fill_dcache), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_dirty(1'b0),
    .clr_en(clr_i), .clr_idx(walk_idx),
    .rd_idx(walk_idx), .rd_valid(i_rd_valid), .rd_tag(i_rd_tag), .rd_dirty(i_rd_dirty),
    .pr_idx(probe_idx), .pr_valid(i_pr_valid), .pr_tag(i_pr_tag), .pr_dirty(i_pr_dirty)
  );

  cmo_tag_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .HAS_DIRTY(1'b1)) u_dtags (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_ok & fill_dcache), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_dirty(fill_dirty),
    .clr_en(clr_d), .clr_idx(walk_idx),
    .rd_idx(walk_idx), .rd_valid(d_rd_valid), .rd_tag(d_rd_tag), .rd_dirty(d_rd_dirty),
    .pr_idx(probe_idx), .pr_valid(d_pr_valid), .pr_tag(d_pr_tag), .pr_dirty(d_pr_dirty)
  );

  cmo_line_data #(.LINES(LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_ddata (
    .clk(clk), .wr_en(fill_ok & fill_dcache), .wr_idx(fill_idx), .wr_line(fill_data),
    .rd_idx(walk_idx), .rd_line(line_data)
  );

  cmo_scope_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PAGE_BITS(PAGE_BITS)) u_imatch (
    .scope(cur_scope), .ref_addr(cur_addr), .line_valid(i_rd_valid),
    .line_tag(i_rd_tag), .line_idx(walk_idx), .hit(i_match)
  );

  cmo_scope_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PAGE_BITS(PAGE_BITS)) u_dmatch (
    .scope(cur_scope), .ref_addr(cur_addr), .line_valid(d_rd_valid),
    .line_tag(d_rd_tag), .line_idx(walk_idx), .hit(d_match)
  );

  cmo_walker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BEATS(BEATS), .LINES(LINES)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd(cmd), .cmd_addr(cmd_addr),
    .busy(busy), .cur_scope(cur_scope), .cur_addr(cur_addr), .walk_idx(walk_idx),
    .i_match(i_match), .d_match(d_match), .d_dirty(d_rd_dirty), .d_tag(d_rd_tag),
    .line_data(line_data), .clr_i(clr_i), .clr_d(clr_d),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_last(wr_last)
  );

  logic unused_i_dirty;
  assign unused_i_dirty = i_rd_dirty | i_pr_dirty;

  assign probe_ihit   = i_pr_valid & (i_pr_tag == probe_tag);
  assign probe_dhit   = d_pr_valid & (d_pr_tag == probe_tag);
  assign probe_ddirty = probe_dhit & d_pr_dirty;
endmodule

// File: rtl/cmo_seq_chk.sv
module cmo_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int BEATS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              busy,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              wr_last
);
  localparam int OFF_W = $clog2(BEATS) + $clog2(WORD_W / 8);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy); // R2

  AST_TRAFFIC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy); // R8

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_last)); // R11

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !wr_last |=> wr_valid && (wr_addr == $past(wr_addr) + STEP)); // R9

  AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> (wr_addr[OFF_W-1:0] == '0)); // R9
endmodule

bind cmo_seq cmo_seq_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BEATS(BEATS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .busy(busy),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_last(wr_last)
);

// File: tb/cmo_seq_test.sv
`timescale 1ns/1ps
module cmo_seq_test;
  localparam logic [19:0] PG  = 20'h12345;
  localparam logic [19:0] PG2 = 20'h0ABCD;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [1:0]   cmd_sel = '0, cmd_scope = '0;
  logic [31:0]  cmd_addr = '0;
  logic         cmd_ready, busy;
  logic         fill_en = 1'b0, fill_dcache = 1'b0, fill_dirty = 1'b0;
  logic [31:0]  fill_addr = '0;
  logic [127:0] fill_data = '0;
  logic [31:0]  probe_addr = '0;
  logic         probe_ihit, probe_dhit, probe_ddirty;
  logic         wr_valid, wr_last;
  logic         wr_ready = 1'b0;
  logic [31:0]  wr_addr, wr_data;

  cmo_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_scope(cmd_scope), .cmd_addr(cmd_addr),
    .busy(busy), .fill_en(fill_en), .fill_dcache(fill_dcache), .fill_addr(fill_addr),
    .fill_dirty(fill_dirty), .fill_data(fill_data), .probe_addr(probe_addr),
    .probe_ihit(probe_ihit), .probe_dhit(probe_dhit), .probe_ddirty(probe_ddirty),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_last(wr_last)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        mi_v [64];
  logic        md_v [64];
  logic        md_d [64];
  logic [21:0] mtag [64];
  logic [31:0] ex_addr [256];
  logic [31:0] ex_data [256];
  int ex_n = 0;
  int got_n = 0;
  int rcnt = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] tag_of(input int i);
    logic [1:0] lo = 2'(i);
    return (i % 2 == 1) ? {PG, lo} : {PG2, lo};
  endfunction

  function automatic logic [31:0] word_of(input int i, input int k);
    return 32'hA000_0000 | (32'(i) << 8) | 32'(k);
  endfunction

  // write-port monitor: picks ready for the coming edge, then records a transfer
  always @(negedge clk) begin
    rcnt++;
    wr_ready = (rcnt % 3 != 1);
    if (rst_n && wr_valid && wr_ready) begin
      if (got_n < ex_n) begin
        chk(wr_addr == ex_addr[got_n], "R9 beat address", wr_addr, ex_addr[got_n]);
        chk(wr_data == ex_data[got_n], "R9 beat data", wr_data, ex_data[got_n]);
        chk(wr_last == (got_n % 4 == 3), "R9 last flag", 32'(wr_last), 32'(got_n % 4 == 3));
      end else begin
        chk(1'b0, "R10 unexpected write", wr_addr, 32'hFFFF_FFFF);
      end
      got_n++;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    fill_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 64; i++) begin
      mi_v[i] = 1'b0; md_v[i] = 1'b0; md_d[i] = 1'b0; mtag[i] = tag_of(i);
    end
  endtask

  task automatic probe_all(input string req);
    for (int i = 0; i < 64; i++) begin
      probe_addr = {mtag[i], 6'(i), 4'h0};
      #1;
      chk(probe_ihit == mi_v[i], req, 32'(probe_ihit), 32'(mi_v[i]));
      chk(probe_dhit == md_v[i], req, 32'(probe_dhit), 32'(md_v[i]));
      chk(probe_ddirty == (md_v[i] & md_d[i]), req, 32'(probe_ddirty), 32'(md_v[i] & md_d[i]));
    end
  endtask

  task automatic fill_all();
    for (int i = 0; i < 64; i++) begin
      if (i % 8 != 7) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          fill_en = 1'b1;
          fill_dcache = (c == 1);
          fill_addr = {tag_of(i), 6'(i), 4'h0};
          fill_dirty = (c == 1) && (i % 3 == 0);
          for (int k = 0; k < 4; k++) fill_data[32*k +: 32] = word_of(i, k);
        end
        mi_v[i] = 1'b1; md_v[i] = 1'b1; md_d[i] = (i % 3 == 0);
      end
    end
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  function automatic bit in_scope(input int i, input logic [1:0] sc, input logic [31:0] a);
    logic [27:0] ln = {mtag[i], 6'(i)};
    case (sc)
      2'd0: return ln == a[31:4];
      2'd1: return ln[27:8] == a[31:12];
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_cmd(input logic op, input logic [1:0] sel, input logic [1:0] sc,
                         input logic [31:0] a, input bit inject, input string req);
    int first, lastx, cyc, guard;
    ex_n = 0;
    got_n = 0;
    first = (sc == 2'd0) ? int'(a[9:4]) : 0;
    lastx = (sc == 2'd0) ? first : 63;
    for (int i = first; i <= lastx; i++) begin
      bit m = in_scope(i, sc, a);
      bit im = sel[0] & mi_v[i] & m;
      bit dm = sel[1] & md_v[i] & m;
      if (dm && md_d[i] && op) begin
        for (int k = 0; k < 4; k++) begin
          ex_addr[ex_n] = {mtag[i], 6'(i), 2'(k), 2'b00};
          ex_data[ex_n] = word_of(i, k);
          ex_n++;
        end
      end
      if (im) mi_v[i] = 1'b0;
      if (dm) begin md_v[i] = 1'b0; md_d[i] = 1'b0; end
    end
    @(negedge clk);
    chk(busy == 1'b0 && cmd_ready == 1'b1, "R2 idle before command", 32'(busy), 32'd0);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_scope = sc; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
    if (inject) begin
      // a competing command and a fill, both offered while busy, must have no effect
      cmd_valid = 1'b1; cmd_op = 1'b0; cmd_sel = 2'b11; cmd_scope = 2'd2;
      fill_en = 1'b1; fill_dcache = 1'b1; fill_dirty = 1'b1;
      fill_addr = {tag_of(7), 6'd7, 4'h0};
    end
    cyc = 1;
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      fill_en = 1'b0;
      if (busy) cyc++;
      guard++;
    end
    chk(guard < 20000, "R2 command completes", 32'(guard), 32'd20000);
    chk(got_n == ex_n, {req, " write count"}, 32'(got_n), 32'(ex_n));
    if (ex_n == 0) begin
      chk(cyc == ((sc == 2'd0) ? 1 : 64), {req, " busy length (R4/R6)"}, 32'(cyc),
          32'((sc == 2'd0) ? 1 : 64));
    end
    probe_all({req, " cache state"});
  endtask

  initial begin
    // R1: reset state
    do_reset();
    chk(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", 32'(cmd_ready), 32'd1);
    chk(wr_valid == 1'b0, "R1 wr_valid", 32'(wr_valid), 32'd0);
    probe_all("R1 empty after reset");

    // R3: fills become visible through the probe
    fill_all();
    probe_all("R3 fill contents");

    // R3 / R2: fill and command during busy are ignored
    run_cmd(1'b0, 2'b01, 2'd2, 32'h0, 1'b1, "R3 R2 ignored while busy");
    probe_addr = {tag_of(7), 6'd7, 4'h0};
    #1;
    chk(probe_dhit == 1'b0, "R3 fill while busy", 32'(probe_dhit), 32'd0);

    // R4..R10: sweep operation x select x scope
    for (int op = 0; op < 2; op++) begin
      for (int sel = 1; sel < 4; sel++) begin
        for (int sc = 0; sc < 4; sc++) begin
          logic [31:0] a;
          do_reset();
          fill_all();
          case (sc)
            0: a = {tag_of(9), 6'd9, 4'h4};
            1: a = {PG, 12'h5A0};
            default: a = 32'h0;
          endcase
          run_cmd(1'(op), 2'(sel), 2'(sc), a, 1'b0,
                  op == 0 ? "R8 R7 R4 R5 R6 invalidate sweep" : "R9 R10 R7 R4 R5 R6 push sweep");
        end
      end
    end

    // R4: line scope with a mismatching tag changes nothing
    do_reset();
    fill_all();
    run_cmd(1'b1, 2'b11, 2'd0, {tag_of(9) ^ 22'h4, 6'd9, 4'h0}, 1'b0, "R4 tag mismatch");

    // R10: push over an empty cache makes no traffic
    run_cmd(1'b0, 2'b11, 2'd2, 32'h0, 1'b0, "R8 clear all");
    run_cmd(1'b1, 2'b11, 2'd2, 32'h0, 1'b0, "R10 push on empty");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule